// File: doc/BRIEF.md
# Banked Register File Addressing Unit

This block is an 8-bit data store for a small processor, together with the front-end that turns each access into one physical location. Two addressing paths exist. A direct access uses the 7-bit location carried in the instruction and a bank taken from two bank-select bits of a status register. An indirect access goes through a virtual data register at location 00h. That register has no storage. It forwards the access to the address held in an 8-bit pointer register, extended by one further bank bit from the status register.

The pointer and the status register are ordinary readable and writable locations of the file. They are also driven out as ports, so that neighbouring logic can observe them. Writes take effect on the rising clock edge. Reads are combinational from the resolved address. Only the lower banks hold RAM; accesses that resolve into higher banks find nothing there. Instruction decode, the ALU and status-flag updates belong to other blocks.

Top module: `rfb_core`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is active and right after it, the pointer register (`ptr_o`) and the status register (`status_o`) read 00h.
- R2: A non-zero `file_addr` is a direct access to effective address {status[6], status[5], file_addr[6:0]}: bits 8:7 are the bank, bits 6:0 are the location inside the bank.
- R3: `file_addr` = 00h is an indirect access to effective address {status[7], pointer[7:0]}, split into bank and location in the same way as R2.
- R4: An indirect access whose effective location is 00h points at the virtual register itself (pointer 00h or 80h). Reading it returns 00h.
- R5: A write to that self-referencing location is a no-operation: pointer, status and every RAM byte keep their values.
- R6: Location 03h of every bank is the status register and location 04h of every bank is the pointer register. Both are read and written through either addressing path, and their contents appear on `status_o` and `ptr_o`.
- R7: Any other location that resolves to bank 2 or bank 3 (effective address 100h–1FFh) reads 00h, and writes to it change nothing.
- R8: With `wr_en` high, the addressed location takes `wr_data` at the rising clock edge. With `rd_en` high, `rd_data` shows the resolved location in the same cycle, before that edge. With `rd_en` low, `rd_data` is 00h.
- R9: A loop that loads the pointer with 20h, writes 00h through location 00h and increments the pointer until pointer bit 4 is set clears bank-0 locations 20h–2Fh and leaves 1Fh and 30h untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pointer and status |
| file_addr | input | 7 | Location field from the instruction; 00h selects the indirect path |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Byte read from the resolved location |
| ptr_o | output | 8 | Current pointer register |
| status_o | output | 8 | Current status register |

## Verification
The bench builds the block with its default parameters: 7-bit locations, 8-bit data, a 2-bit bank select, two populated banks, status at 03h and pointer at 04h. With these values the whole 9-bit effective space can be reached. A random status value reaches the two empty banks. A random pointer with the extra bank bit set reaches them through the indirect path. Pointer values 00h and 80h reach the self-referencing case from both low banks. The 256 populated bytes are few enough to fill with a known pattern first, so that every later read can be predicted.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  // Destination that one access resolves to.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_PTR  = 2'd2,
    TGT_STAT = 2'd3
  } tgt_e;
endpackage

// File: rtl/rfb_resolve.sv
module rfb_resolve
  import rfb_pkg::*;
#(
  parameter int LOC_W     = 7,
  parameter int DATA_W    = 8,
  parameter int BSEL_W    = 2,
  parameter int POP_BANKS = 2,
  parameter int PTR_LOC   = 4,
  parameter int STAT_LOC  = 3,
  parameter int RP_LO_BIT = 5,
  parameter int IRP_BIT   = 7
) (
  input  logic [LOC_W-1:0]  file_addr,
  input  logic [DATA_W-1:0] ptr_q,
  input  logic [DATA_W-1:0] stat_q,
  output tgt_e              tgt,
  output logic [BSEL_W-1:0] bank,
  output logic [LOC_W-1:0]  loc,
  output logic              self_ref,
  output logic              unpop
);
  localparam int EA_W = LOC_W + BSEL_W;

  // Direct path: bank bits of the status register above the opcode location.
  function automatic logic [EA_W-1:0] direct_ea(input logic [DATA_W-1:0] st,
                                                input logic [LOC_W-1:0] a);
    return {st[RP_LO_BIT +: BSEL_W], a};
  endfunction

  // Indirect path: one extra bank bit above the full pointer.
  function automatic logic [EA_W-1:0] indirect_ea(input logic [DATA_W-1:0] st,
                                                  input logic [DATA_W-1:0] p);
    return EA_W'({st[IRP_BIT], p});
  endfunction

  function automatic logic bank_populated(input logic [BSEL_W-1:0] b);
    return int'(b) < POP_BANKS;
  endfunction

  logic            via_ptr;
  logic [EA_W-1:0] ea;

  assign via_ptr = (file_addr == '0);
  assign ea      = via_ptr ? indirect_ea(stat_q, ptr_q) : direct_ea(stat_q, file_addr);
  assign bank    = ea[EA_W-1 -: BSEL_W];
  assign loc     = ea[LOC_W-1:0];

  always_comb begin
    self_ref = 1'b0;
    unpop    = 1'b0;
    if (loc == '0) begin
      tgt      = TGT_NONE;
      self_ref = 1'b1;
    end else if (loc == LOC_W'(STAT_LOC)) begin
      tgt = TGT_STAT;
    end else if (loc == LOC_W'(PTR_LOC)) begin
      tgt = TGT_PTR;
    end else if (bank_populated(bank)) begin
      tgt = TGT_RAM;
    end else begin
      tgt   = TGT_NONE;
      unpop = 1'b1;
    end
  end
endmodule

// File: rtl/rfb_sfr.sv
module rfb_sfr #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr_q,
  output logic [DATA_W-1:0] stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      stat_q <= '0;
    end else begin
      if (ptr_we)  ptr_q  <= wdata;
      if (stat_we) stat_q <= wdata;
    end
  end
endmodule

// File: rtl/rfb_ram.sv
module rfb_ram #(
  parameter int LOC_W     = 7,
  parameter int DATA_W    = 8,
  parameter int BSEL_W    = 2,
  parameter int POP_BANKS = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BSEL_W-1:0] bank,
  input  logic [LOC_W-1:0]  loc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << LOC_W;

  logic [DATA_W-1:0] bank_rd [POP_BANKS];

  for (genvar b = 0; b < POP_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && bank == BSEL_W'(b)) mem[loc] <= wdata;
    end
    assign bank_rd[b] = mem[loc];
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < POP_BANKS; b++) begin
      if (bank == BSEL_W'(b)) rdata = bank_rd[b];
    end
  end
endmodule

// File: rtl/rfb_core.sv
module rfb_core
  import rfb_pkg::*;
#(
  parameter int LOC_W     = 7,
  parameter int DATA_W    = 8,
  parameter int BSEL_W    = 2,
  parameter int POP_BANKS = 2,
  parameter int PTR_LOC   = 4,
  parameter int STAT_LOC  = 3,
  parameter int RP_LO_BIT = 5,
  parameter int IRP_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOC_W-1:0]  file_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ptr_o,
  output logic [DATA_W-1:0] status_o
);
  tgt_e              tgt;
  logic [BSEL_W-1:0] bank;
  logic [LOC_W-1:0]  loc;
  logic              self_ref;
  logic              unpop;
  logic              ram_we;
  logic              ptr_we;
  logic              stat_we;
  logic [DATA_W-1:0] ram_rd;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] sel_rd;

  rfb_resolve #(
    .LOC_W(LOC_W), .DATA_W(DATA_W), .BSEL_W(BSEL_W), .POP_BANKS(POP_BANKS),
    .PTR_LOC(PTR_LOC), .STAT_LOC(STAT_LOC), .RP_LO_BIT(RP_LO_BIT), .IRP_BIT(IRP_BIT)
  ) i_resolve (
    .file_addr (file_addr),
    .ptr_q     (ptr_q),
    .stat_q    (stat_q),
    .tgt       (tgt),
    .bank      (bank),
    .loc       (loc),
    .self_ref  (self_ref),
    .unpop     (unpop)
  );

  // Named write events, one per destination.
  assign ram_we  = wr_en && (tgt == TGT_RAM);
  assign ptr_we  = wr_en && (tgt == TGT_PTR);
  assign stat_we = wr_en && (tgt == TGT_STAT);

  rfb_sfr #(.DATA_W(DATA_W)) i_sfr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr_we  (ptr_we),
    .stat_we (stat_we),
    .wdata   (wr_data),
    .ptr_q   (ptr_q),
    .stat_q  (stat_q)
  );

  rfb_ram #(
    .LOC_W(LOC_W), .DATA_W(DATA_W), .BSEL_W(BSEL_W), .POP_BANKS(POP_BANKS)
  ) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .bank  (bank),
    .loc   (loc),
    .wdata (wr_data),
    .rdata (ram_rd)
  );

  always_comb begin
    unique case (tgt)
      TGT_RAM:  sel_rd = ram_rd;
      TGT_PTR:  sel_rd = ptr_q;
      TGT_STAT: sel_rd = stat_q;
      default:  sel_rd = '0;
    endcase
  end

  assign rd_data  = rd_en ? sel_rd : '0;
  assign ptr_o    = ptr_q;
  assign status_o = stat_q;
endmodule

// File: rtl/rfb_core_chk.sv
module rfb_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] ptr_o,
  input logic [DATA_W-1:0] status_o,
  input logic              self_ref,
  input logic              unpop,
  input logic              ram_we,
  input logic              ptr_we,
  input logic              stat_we
);
  p_self_rd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && self_ref) |-> (rd_data == '0));

  p_self_wr_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && self_ref) |-> (!ram_we && !ptr_we && !stat_we));

  p_self_wr_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && self_ref) |=> ($stable(ptr_o) && $stable(status_o)));

  p_unpop_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unpop) |-> (rd_data == '0));

  p_unpop_wr_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unpop) |-> !ram_we);

  p_one_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, ptr_we, stat_we}));

  p_ptr_takes_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (ptr_o == $past(wr_data)));

  p_stat_takes_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> (status_o == $past(wr_data)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ptr_o) && $stable(status_o)));
endmodule

bind rfb_core rfb_core_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .ptr_o    (ptr_o),
  .status_o (status_o),
  .self_ref (self_ref),
  .unpop    (unpop),
  .ram_we   (ram_we),
  .ptr_we   (ptr_we),
  .stat_we  (stat_we)
);

// File: tb/test_rfb_core.sv
module test_rfb_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] file_addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, ptr_o, status_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // Expected-state model, kept in terms of the requirements.
  logic [7:0] m_mem [512];
  logic [7:0] m_ptr = 8'h00;
  logic [7:0] m_st  = 8'h00;

  rfb_core i_rfb_core (
    .clk(clk), .rst_n(rst_n), .file_addr(file_addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ptr_o(ptr_o), .status_o(status_o)
  );

  always #5 clk = ~clk;

  // R2/R3: 9-bit effective address; bank in bits 8:7.
  function automatic logic [8:0] m_ea(input logic [6:0] a);
    if (a == 7'h00) return {m_st[7], m_ptr};
    return {m_st[6], m_st[5], a};
  endfunction

  function automatic logic [7:0] m_read(input logic [6:0] a);
    logic [8:0] e;
    e = m_ea(a);
    if (e[6:0] == 7'h00) return 8'h00;      // R4
    if (e[6:0] == 7'h03) return m_st;       // R6
    if (e[6:0] == 7'h04) return m_ptr;      // R6
    if (e[8:7] >= 2'd2) return 8'h00;       // R7
    return m_mem[e];
  endfunction

  task automatic m_write(input logic [6:0] a, input logic [7:0] d);
    logic [8:0] e;
    e = m_ea(a);
    if (e[6:0] == 7'h00) return;            // R5
    if (e[6:0] == 7'h03) m_st = d;
    else if (e[6:0] == 7'h04) m_ptr = d;
    else if (e[8:7] < 2'd2) m_mem[e] = d;
  endtask

  function automatic logic [7:0] init_pat(input logic [8:0] e);
    return e[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample read before the edge, registers after it.
  task automatic op(input logic [6:0] a, input bit rd, input bit wr,
                    input logic [7:0] d, input string req);
    @(negedge clk);
    file_addr = a; rd_en = rd; wr_en = wr; wr_data = d;
    #1;
    if (rd) chk(req, rd_data, m_read(a));
    else    chk("R8 idle read", rd_data, 8'h00);
    @(posedge clk);
    if (wr) m_write(a, d);
    #1;
    chk({req, " ptr"}, ptr_o, m_ptr);
    chk({req, " status"}, status_o, m_st);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [6:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    file_addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    chk(req, rd_data, exp);
    @(posedge clk);
    #1;
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] p;
    void'($urandom(32'h1A2B3C4D));

    // R1: reset values while reset is held and after release.
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ptr in reset", ptr_o, 8'h00);
    chk("R1 status in reset", status_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 ptr after reset", ptr_o, 8'h00);
    chk("R1 status after reset", status_o, 8'h00);

    // Fill both populated banks with a known pattern by direct writes (R2).
    for (int b = 0; b < 2; b++) begin
      op(7'h03, 1'b0, 1'b1, (b == 1) ? 8'h20 : 8'h00, "R6 bank select");
      for (int l = 1; l < 128; l++) begin
        if (l != 3 && l != 4)
          op(7'(l), 1'b0, 1'b1, init_pat({b[1:0], 7'(l)}), "R2 fill");
      end
    end
    op(7'h03, 1'b0, 1'b1, 8'h00, "R6 bank 0");

    // R9: indirect clearing loop.
    op(7'h04, 1'b0, 1'b1, 8'h20, "R9 load pointer");
    do begin
      op(7'h00, 1'b0, 1'b1, 8'h00, "R9 clear via indirect");
      p = ptr_o;
      op(7'h04, 1'b0, 1'b1, p + 8'h01, "R9 increment");
    end while (!ptr_o[4]);
    chk("R9 final pointer", ptr_o, 8'h30);
    for (int l = 8'h20; l < 8'h30; l++) rd_expect(7'(l), 8'h00, "R9 cleared");
    rd_expect(7'h1F, init_pat(9'h01F), "R9 neighbour below");
    rd_expect(7'h30, init_pat(9'h030), "R9 neighbour above");

    // R2: direct access into bank 1 and back to bank 0.
    op(7'h03, 1'b0, 1'b1, 8'h20, "R2 select bank 1");
    op(7'h25, 1'b0, 1'b1, 8'hC3, "R2 bank 1 write");
    rd_expect(7'h25, 8'hC3, "R2 bank 1 read");
    op(7'h03, 1'b0, 1'b1, 8'h00, "R2 select bank 0");
    rd_expect(7'h25, 8'h00, "R2 bank 0 cleared byte");

    // R3: indirect with the pointer above 7Fh reaches bank 1.
    op(7'h04, 1'b0, 1'b1, 8'hA5, "R3 pointer");
    rd_expect(7'h00, 8'hC3, "R3 indirect into bank 1");

    // R4/R5: self-referencing indirect, pointer 00h and 80h.
    op(7'h04, 1'b0, 1'b1, 8'h00, "R4 pointer zero");
    rd_expect(7'h00, 8'h00, "R4 self read");
    op(7'h00, 1'b0, 1'b1, 8'hEE, "R5 self write");
    chk("R5 pointer kept", ptr_o, 8'h00);
    chk("R5 status kept", status_o, 8'h00);
    rd_expect(7'h01, init_pat(9'h001), "R5 ram kept");
    op(7'h04, 1'b0, 1'b1, 8'h80, "R4 pointer 80h");
    rd_expect(7'h00, 8'h00, "R4 self read bank 1");
    op(7'h00, 1'b0, 1'b1, 8'hEE, "R5 self write bank 1");
    rd_expect(7'h04, 8'h80, "R5 pointer kept");

    // R6: special registers through the indirect path.
    op(7'h04, 1'b0, 1'b1, 8'h03, "R6 pointer at status");
    rd_expect(7'h00, 8'h00, "R6 status via indirect");
    op(7'h04, 1'b0, 1'b1, 8'h84, "R6 pointer at pointer, bank 1");
    op(7'h00, 1'b0, 1'b1, 8'h33, "R6 pointer write via indirect");
    chk("R6 pointer updated", ptr_o, 8'h33);

    // R7: unpopulated banks.
    op(7'h03, 1'b0, 1'b1, 8'h40, "R7 select bank 2");
    op(7'h30, 1'b0, 1'b1, 8'h77, "R7 write bank 2");
    rd_expect(7'h30, 8'h00, "R7 read bank 2");
    op(7'h03, 1'b0, 1'b1, 8'h80, "R7 extra bank bit");
    op(7'h04, 1'b0, 1'b1, 8'h10, "R7 pointer");
    rd_expect(7'h00, 8'h00, "R7 indirect into bank 2");
    op(7'h03, 1'b0, 1'b1, 8'h00, "R7 back to bank 0");
    rd_expect(7'h30, init_pat(9'h030), "R7 bank 0 untouched");

    // Random mix against the model (R2, R3, R6, R7, R8).
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] a;
      logic [7:0] d;
      int sel;
      sel = int'($urandom_range(0, 7));
      case (sel)
        0: a = 7'h00;
        1: a = 7'h03;
        2: a = 7'h04;
        default: a = 7'($urandom);
      endcase
      d = 8'($urandom);
      if (a == 7'h03 && $urandom_range(0, 3) != 0) d = d & 8'h3F;
      op(a, 1'($urandom), 1'($urandom), d, "R8 random access");
    end

    done = 1'b1;
    finish_run();
  end
endmodule